// File: doc/BRIEF.md
# Synchronous Burst Static Memory Core

This block is a synthesizable behavioural model of a clocked static memory with a two-bit burst address generator. It is meant for system models and emulation builds that need the cycle behaviour of such a memory: when read data appears, when the outputs are driven, and which commands a sleep period blocks. Voltages and analog timing are not modelled. The data bus is split into a write-data input, a read-data output and an output-drive flag.

Every control input is sampled on the rising clock edge, except the output enable and the read-path mode. Two address strobes can start an access: a processor strobe, which always reads, and a controller strobe, which reads or writes. A cycle with neither strobe continues the current burst, either moving to the next address or staying on the current one. A mode input picks a one-edge (flow-through) or two-edge (pipelined) read latency. Outputs turn off one stage earlier than pipelined read data arrives. A sleep input freezes the memory after a two-edge delay. When sleep ends, a recovery window of a set number of clock edges follows, during which writes are refused and flagged.

Top module: `sburst_sram`

## Requirements
- R1: The chip counts as enabled only when `ce2`=1, `ce1_n`=0 and `ce3_n`=0 at a strobe edge. The processor strobe is ignored while `ce1_n`=1: with `strb_c_n`=1 that edge is then a plain continue cycle. A strobe accepted while the chip is not enabled is a deselect, and it writes nothing.
- R2: A start by the processor strobe always reads, whatever the write controls are. A start by the controller strobe reads or writes according to R3, and its write data is taken from `din` on the same edge.
- R3: `gwr_n`=0 writes all bytes. Otherwise `bwr_n`=0 writes each byte i that has `be_n[i]`=0, where byte i is `din[8i+7:8i]`. With both `gwr_n` and `bwr_n` high the cycle is a read.
- R4: A read returns the whole word, whatever the values of `be_n`.
- R5: A start loads the counter. An edge with no strobe and `adv_n`=0 moves to the next address, and an edge with no strobe and `adv_n`=1 repeats the current address. With `lin_order`=1 the low two address bits go start+n mod 4. With `lin_order`=0 they go start XOR n. The sequence wraps after four addresses.
- R6: With `pipe_mode`=0, data for a read captured at edge k is driven in the cycle that follows edge k.
- R7: With `pipe_mode`=1, data for a read captured at edge k is driven in the cycle that follows edge k+1, provided the command captured at edge k+1 is also a read.
- R8: A deselect or a write captured at edge j forces `dout_en` low in the cycle that follows edge j, in either mode.
- R9: `oe_n`=1 forces `dout_en` low at once, without waiting for a clock edge. `oe_n`=0 lets read data be driven again.
- R10: When `sleep_req` is first seen high at edge j, commands from edge j+2 onward are ignored and the outputs are off. Stored data is kept.
- R11: When `sleep_req` is first seen low at edge m, commands resume at edge m+2. A write at an edge from m+2 to m+1+`REC_CYCLES` is dropped, and `wr_err` is high in the cycle that follows that edge. Reads in that window work normally.
- R12: After reset, `dout_en` and `wr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | External address |
| ce1_n | input | 1 | Chip enable, active low; also masks the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| strb_p_n | input | 1 | Processor address strobe, active low |
| strb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Write of all bytes, active low |
| bwr_n | input | 1 | Byte write, active low |
| be_n | input | NB | Per-byte write enables, active low |
| oe_n | input | 1 | Output enable, active low, takes effect without a clock edge |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through reads |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep_req | input | 1 | Sleep request, active high |
| din | input | NB*BYTE_W | Write data |
| dout | output | NB*BYTE_W | Read data |
| dout_en | output | 1 | High when `dout` would drive the bus |
| wr_err | output | 1 | Pulse for a write dropped during recovery |

## Verification
The bench builds the core with a 64-word depth, two 8-bit byte lanes and a three-edge recovery window. The small depth keeps every address used in the directed sequences easy to follow. Two lanes are enough to tell a partial write from a full one. The short window lets the bench reach both a refused write inside recovery and an accepted write right after it. Both read modes and both burst orders are exercised on the same build by switching the mode inputs between deselect cycles.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
// Shared types for the burst memory core.
// Assumes: the burst counter covers the two low address bits only.
package sbs_pkg;
    // Decoded command of one clock edge
    typedef enum logic [1:0] {OP_NOP, OP_DESEL, OP_RD, OP_WR} op_e;

    // Low address bits for burst step `step` from start `base`
    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] step,
                                            input logic       lin);
        return lin ? (base + step) : (base ^ step);
    endfunction
endpackage

// File: rtl/sbs_burst_ctr.sv
`timescale 1ns/1ps
// Burst address generator. Holds the upper address bits, the two-bit
// start value and a step count. Produces the address that this edge
// accesses. Assumes AW >= 3, and that `step` is high only for edges
// that really access memory.
module sbs_burst_ctr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          adv,
    input  logic          lin,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] acc_addr
);
    import sbs_pkg::*;
    localparam int HW = AW - 2;

    logic [HW-1:0] hi_q;
    logic [1:0]    base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_nx;

    // Step count used by a continue cycle
    always_comb cnt_nx = cnt_q + {1'b0, adv};

    // Address accessed on this edge
    always_comb acc_addr = load ? ext_addr : {hi_q, burst_lo(base_q, cnt_nx, lin)};

    // Load on a start, advance on a continue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (step) begin
            if (load) begin
                hi_q   <= ext_addr[AW-1:2];
                base_q <= ext_addr[1:0];
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_nx;
            end
        end
    end
endmodule

// File: rtl/sbs_cmd.sv
`timescale 1ns/1ps
// Command decoder. Turns the strobes, enables and write controls of one
// edge into a command, a counter load/advance and per-byte write enables.
// Assumes `asleep` and `in_rec` come from the sleep sequencer.
module sbs_cmd #(
    parameter int NB = 2
) (
    input  logic          strb_p_n,
    input  logic          strb_c_n,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          adv_n,
    input  logic          gwr_n,
    input  logic          bwr_n,
    input  logic [NB-1:0] be_n,
    input  logic          asleep,
    input  logic          in_rec,
    output sbs_pkg::op_e  op,
    output logic          load,
    output logic          adv,
    output logic [NB-1:0] byte_we,
    output logic          drop_wr
);
    import sbs_pkg::*;

    logic p_start;
    logic chip_on;
    logic wr_req;

    // Processor strobe counts only while the first enable is active
    assign p_start = !strb_p_n && !ce1_n;
    assign chip_on = ce2 && !ce1_n && !ce3_n;
    assign wr_req  = !gwr_n || !bwr_n;

    // Decode of the command for this edge
    always_comb begin
        op      = OP_NOP;
        load    = 1'b0;
        adv     = 1'b0;
        drop_wr = 1'b0;
        if (!asleep) begin
            if (p_start) begin
                op   = chip_on ? OP_RD : OP_DESEL;
                load = chip_on;
            end else if (!strb_c_n) begin
                op   = !chip_on ? OP_DESEL : (wr_req ? OP_WR : OP_RD);
                load = chip_on;
            end else begin
                op   = wr_req ? OP_WR : OP_RD;
                adv  = !adv_n;
            end
            if (op == OP_WR && in_rec) begin
                op      = OP_NOP;
                drop_wr = 1'b1;
            end
        end
        byte_we = (op == OP_WR) ? (gwr_n ? ~be_n : '1) : '0;
    end
endmodule

// File: rtl/sbs_sleep.sv
`timescale 1ns/1ps
// Sleep sequencer. Delays the sleep request by two edges and opens a
// recovery window of REC_CYCLES edges once sleep ends. Assumes
// REC_CYCLES >= 1.
module sbs_sleep #(
    parameter int REC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic asleep,
    output logic in_rec
);
    localparam int RW = $clog2(REC_CYCLES + 1);

    logic          s1_q;
    logic          s2_q;
    logic [RW-1:0] rec_q;

    // Two-stage delay of the request and the recovery countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            rec_q <= '0;
        end else begin
            s1_q <= sleep_req;
            s2_q <= s1_q;
            if (s2_q && !s1_q)
                rec_q <= RW'(REC_CYCLES);
            else if (rec_q != '0)
                rec_q <= rec_q - RW'(1);
        end
    end

    assign asleep = s2_q;
    assign in_rec = (rec_q != '0);

    // R11
    wake_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> in_rec);
endmodule

// File: rtl/sburst_sram.sv
`timescale 1ns/1ps
// Synchronous burst memory core: byte-lane storage, a flow-through or
// pipelined read path, and output turn-off one stage ahead of pipelined
// data. Assumes oe_n and pipe_mode are static around any edge where their
// effect matters; only oe_n acts without a clock edge.
module sburst_sram #(
    parameter int AW         = 6,
    parameter int NB         = 2,
    parameter int BYTE_W     = 8,
    parameter int REC_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    input  logic                 ce1_n,
    input  logic                 ce2,
    input  logic                 ce3_n,
    input  logic                 strb_p_n,
    input  logic                 strb_c_n,
    input  logic                 adv_n,
    input  logic                 gwr_n,
    input  logic                 bwr_n,
    input  logic [NB-1:0]        be_n,
    input  logic                 oe_n,
    input  logic                 pipe_mode,
    input  logic                 lin_order,
    input  logic                 sleep_req,
    input  logic [NB*BYTE_W-1:0] din,
    output logic [NB*BYTE_W-1:0] dout,
    output logic                 dout_en,
    output logic                 wr_err
);
    import sbs_pkg::*;
    localparam int DW    = NB * BYTE_W;
    localparam int DEPTH = 1 << AW;

    op_e           op;
    logic          load;
    logic          adv;
    logic          drop_wr;
    logic [NB-1:0] byte_we;
    logic          asleep;
    logic          in_rec;
    logic          step;
    logic [AW-1:0] acc_addr;
    logic [AW-1:0] a1_q;
    logic          rd1_q;
    logic          v2_q;
    logic [DW-1:0] q2_q;
    logic [DW-1:0] rd_word;

    sbs_sleep #(.REC_CYCLES(REC_CYCLES)) u_sleep (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .asleep(asleep), .in_rec(in_rec)
    );

    sbs_cmd #(.NB(NB)) u_cmd (
        .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adv_n(adv_n), .gwr_n(gwr_n), .bwr_n(bwr_n),
        .be_n(be_n), .asleep(asleep), .in_rec(in_rec), .op(op),
        .load(load), .adv(adv), .byte_we(byte_we), .drop_wr(drop_wr)
    );

    assign step = (op == OP_RD) || (op == OP_WR);

    sbs_burst_ctr #(.AW(AW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .adv(adv),
        .lin(lin_order), .ext_addr(addr), .acc_addr(acc_addr)
    );

    // One storage array per byte lane
    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        // Byte write into this lane
        always_ff @(posedge clk) begin
            if (byte_we[b])
                lane_mem[acc_addr] <= din[b*BYTE_W +: BYTE_W];
        end

        assign rd_word[b*BYTE_W +: BYTE_W] = lane_mem[a1_q];
    end

    // Input stage, output register and dropped-write flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd1_q  <= 1'b0;
            a1_q   <= '0;
            v2_q   <= 1'b0;
            q2_q   <= '0;
            wr_err <= 1'b0;
        end else begin
            rd1_q  <= (op == OP_RD);
            a1_q   <= acc_addr;
            v2_q   <= rd1_q;
            q2_q   <= rd_word;
            wr_err <= drop_wr;
        end
    end

    // Output select and drive gating
    always_comb begin
        dout    = pipe_mode ? q2_q : rd_word;
        dout_en = !oe_n && !asleep && (pipe_mode ? (v2_q && rd1_q) : rd1_q);
    end

    // R8
    wr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR) |=> !dout_en);
    // R8
    desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DESEL) |=> !dout_en);
    // R10
    sleep_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (byte_we == '0));
    // R11
    err_in_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(in_rec));
endmodule

// File: tb/tb_sburst_sram.sv
`timescale 1ns/1ps
module tb_sburst_sram;
    localparam int CLK_P = 10;
    localparam int AW = 6, NB = 2, BYTE_W = 8, REC = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
    logic strb_p_n = 1'b1, strb_c_n = 1'b0, adv_n = 1'b1;
    logic gwr_n = 1'b1, bwr_n = 1'b1;
    logic [NB-1:0] be_n = '1;
    logic oe_n = 1'b0, pipe_mode = 1'b0, lin_order = 1'b1, sleep_req = 1'b0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic dout_en, wr_err;

    int cyc = 0, ecur = 0, checks = 0, errors = 0;
    int q_cyc[$];
    bit q_kind[$];
    bit q_en[$];
    logic [15:0] q_d[$];
    string q_req[$];

    sburst_sram #(.AW(AW), .NB(NB), .BYTE_W(BYTE_W), .REC_CYCLES(REC)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .be_n(be_n), .oe_n(oe_n),
        .pipe_mode(pipe_mode), .lin_order(lin_order), .sleep_req(sleep_req),
        .din(din), .dout(dout), .dout_en(dout_en), .wr_err(wr_err)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Driver: set inputs just after an edge; ecur = edge that captures them
    task automatic drive(input bit sp, input bit sc, input bit c1, input bit c2,
                         input bit c3, input bit av, input bit gw, input bit bw,
                         input logic [1:0] be, input logic [AW-1:0] a,
                         input logic [15:0] d);
        @(posedge clk); #1;
        strb_p_n = sp; strb_c_n = sc; ce1_n = c1; ce2 = c2; ce3_n = c3;
        adv_n = av; gwr_n = gw; bwr_n = bw; be_n = be; addr = a; din = d;
        ecur = cyc + 1;
    endtask
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        drive(1, 0, 0, 1, 0, 1, 0, 1, 2'b11, a, d);
    endtask
    task automatic bwr(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
        drive(1, 0, 0, 1, 0, 1, 1, 0, be, a, d);
    endtask
    task automatic rdc(input logic [AW-1:0] a);
        drive(1, 0, 0, 1, 0, 1, 1, 1, 2'b01, a, 16'h0);
    endtask
    task automatic rdp(input logic [AW-1:0] a);
        drive(0, 1, 0, 1, 0, 1, 0, 1, 2'b00, a, 16'h0);
    endtask
    task automatic cont(input bit av);
        drive(1, 1, 0, 1, 0, av, 1, 1, 2'b11, '0, 16'h0);
    endtask
    task automatic desel();
        drive(1, 0, 1, 1, 0, 1, 1, 1, 2'b11, '0, 16'h0);
    endtask

    // Scoreboard push: output expectation for the cycle after edge c
    task automatic exp_d(input int c, input bit en, input logic [15:0] d, input string r);
        q_cyc.push_back(c); q_kind.push_back(1'b0); q_en.push_back(en);
        q_d.push_back(d); q_req.push_back(r);
    endtask
    task automatic exp_err(input int c, input bit v, input string r);
        q_cyc.push_back(c); q_kind.push_back(1'b1); q_en.push_back(v);
        q_d.push_back(16'h0); q_req.push_back(r);
    endtask

    // Monitor: pop and compare expectations at the falling edge
    always @(negedge clk) begin
        for (int i = q_cyc.size() - 1; i >= 0; i--) begin
            if (q_cyc[i] == cyc) begin
                checks++;
                if (q_kind[i]) begin
                    if (wr_err !== q_en[i]) begin
                        errors++;
                        $display("FAIL %s: wr_err=%b expected %b (cycle %0d)",
                                 q_req[i], wr_err, q_en[i], cyc);
                    end
                end else if (dout_en !== q_en[i] || (q_en[i] && dout !== q_d[i])) begin
                    errors++;
                    $display("FAIL %s: en=%b data=%h expected en=%b data=%h (cycle %0d)",
                             q_req[i], dout_en, dout, q_en[i], q_d[i], cyc);
                end
                q_cyc.delete(i); q_kind.delete(i); q_en.delete(i);
                q_d.delete(i); q_req.delete(i);
            end
        end
    end

    task automatic finish_run();
        if (q_cyc.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", q_cyc.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int e, j, m;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        // R12 reset state
        if (dout_en !== 1'b0 || wr_err !== 1'b0) begin
            errors++;
            $display("FAIL R12: en=%b err=%b expected 0 0", dout_en, wr_err);
        end
        @(posedge clk); #1 rst_n = 1'b1;

        // Flow-through writes and reads
        wr(5, 16'hA1B2);   exp_d(ecur, 0, 0, "R8 write off");
        wr(6, 16'h5566);
        bwr(6, 16'h1234, 2'b10);
        wr(7, 16'h7777);
        bwr(7, 16'hFFFF, 2'b11); exp_d(ecur, 0, 0, "R8 write off");
        rdc(6);            exp_d(ecur, 1, 16'h5534, "R3 R4 R6 byte write");
        rdc(7);            exp_d(ecur, 1, 16'h7777, "R3 no bytes");
        rdp(7);            exp_d(ecur, 1, 16'h7777, "R2 processor read");
        rdc(7);            exp_d(ecur, 1, 16'h7777, "R2 no write");

        // R5 linear burst with wrap and hold
        wr(8, 16'h0808); wr(9, 16'h0909); wr(10, 16'h0A0A); wr(11, 16'h0B0B);
        rdc(10);  exp_d(ecur, 1, 16'h0A0A, "R5");
        cont(0);  exp_d(ecur, 1, 16'h0B0B, "R5");
        cont(0);  exp_d(ecur, 1, 16'h0808, "R5");
        cont(0);  exp_d(ecur, 1, 16'h0909, "R5");
        cont(0);  exp_d(ecur, 1, 16'h0A0A, "R5 wrap");
        cont(1);  exp_d(ecur, 1, 16'h0A0A, "R5 hold");
        desel(); lin_order = 1'b0;
        // R5 interleaved
        rdc(9);   exp_d(ecur, 1, 16'h0909, "R5 interleave");
        cont(0);  exp_d(ecur, 1, 16'h0808, "R5 interleave");
        cont(0);  exp_d(ecur, 1, 16'h0B0B, "R5 interleave");
        cont(0);  exp_d(ecur, 1, 16'h0A0A, "R5 interleave");
        desel(); lin_order = 1'b1;

        // R8 deselect in flow mode
        rdc(5);   exp_d(ecur, 1, 16'hA1B2, "R6");
        desel();  exp_d(ecur, 0, 0, "R8 deselect");

        // R1 enable decoding
        rdc(6);
        drive(0, 1, 1, 1, 0, 1, 1, 1, 2'b11, 6'd3, 16'h0);
        exp_d(ecur, 1, 16'h5534, "R1 masked processor strobe");
        drive(1, 0, 0, 0, 0, 1, 0, 1, 2'b11, 6'd7, 16'h0000); exp_d(ecur, 0, 0, "R1 ce2 low");
        drive(1, 0, 0, 1, 1, 1, 0, 1, 2'b11, 6'd7, 16'h0000); exp_d(ecur, 0, 0, "R1 ce3 high");
        drive(0, 1, 0, 0, 0, 1, 1, 1, 2'b11, 6'd7, 16'h0000); exp_d(ecur, 0, 0, "R1 processor deselect");
        rdc(7);   exp_d(ecur, 1, 16'h7777, "R1 no write");

        // R9 output enable
        rdc(5);   e = ecur;
        rdc(5);   oe_n = 1'b1; exp_d(e, 0, 0, "R9 oe high");
        desel();  oe_n = 1'b0; exp_d(e + 1, 1, 16'hA1B2, "R9 oe low");
        desel();  pipe_mode = 1'b1;
        desel();

        // Pipelined reads
        rdc(5);   e = ecur; exp_d(e, 0, 0, "R7 latency");
        cont(1);  exp_d(e + 1, 1, 16'hA1B2, "R7");
        desel();  exp_d(e + 2, 0, 0, "R8 early turn-off");
        rdc(6);
        wr(12, 16'hC0DE); exp_d(ecur, 0, 0, "R8 write off pipe");
        desel();
        rdc(8);   e = ecur;
        cont(0);  exp_d(e + 1, 1, 16'h0808, "R7 burst");
        cont(0);  exp_d(e + 2, 1, 16'h0909, "R7 burst");
        cont(0);  exp_d(e + 3, 1, 16'h0A0A, "R7 burst");
        cont(1);  exp_d(e + 4, 1, 16'h0B0B, "R7 burst");
        desel();
        rdc(12);  e = ecur;
        cont(1);  exp_d(e + 1, 1, 16'hC0DE, "R7 write then read");
        desel();  pipe_mode = 1'b0;
        desel();

        // Sleep and recovery
        desel();  sleep_req = 1'b1; j = ecur;
        desel();
        wr(5, 16'hDEAD);   exp_d(j + 2, 0, 0, "R10 asleep");
        rdc(5);            exp_d(j + 3, 0, 0, "R10 outputs off");
        desel();  sleep_req = 1'b0; m = ecur;
        desel();
        wr(5, 16'hBEEF);   exp_err(m + 2, 1, "R11 dropped write");
        rdc(5);            exp_d(m + 3, 1, 16'hA1B2, "R10 R11 data kept");
        exp_err(m + 3, 0, "R11 single pulse");
        desel();
        wr(13, 16'h4242);  exp_err(m + 5, 0, "R11 window over");
        rdc(13);           exp_d(m + 6, 1, 16'h4242, "R11 write accepted");
        desel();
        repeat (4) @(posedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule